// File: doc/BRIEF.md
# Display Command Packet Assembler

This block turns one display command (a command byte plus zero or more parameter bytes) into a complete display serial interface packet. It sends the packet as a byte stream over a valid/ready handshake that marks the last byte, for a low-power lane transmitter downstream. The parameter count sets the packet shape. Zero or one parameter gives a four-byte short packet. Two or more give a long packet that carries a 16-bit word count, a header ECC, the payload and a trailing 16-bit checksum. All packets use virtual channel 0.

A request is offered on `req_valid` with the command, the count and a flat parameter buffer. The request is taken in the cycle that `req_ready` is high, which is the case only while the block is idle. The block copies the request, and the first packet byte appears on the cycle after acceptance. The header ECC is formed from the stored header. The checksum is updated one byte per accepted payload byte while the payload streams out. A request whose count exceeds the buffer depth is dropped and flagged with a one-cycle `err` pulse.

The controller has four states:
- IDLE: waits for a request.
- HEADER: sends 4 bytes.
- PAYLOAD: sends the command, then the parameters.
- CHECKSUM: sends 2 bytes.

Its transitions are:
- accept (IDLE→HEADER)
- reject (IDLE→IDLE, with `err`)
- short done (HEADER→IDLE)
- header done (HEADER→PAYLOAD)
- payload done (PAYLOAD→CHECKSUM)
- packet done (CHECKSUM→IDLE)

Top module: `dcs_pkt_asm`

## Requirements
- R1: With a count of 0 the block sends exactly 4 bytes, in this order: 0x05, the command, 0x00, ECC. `out_last` is high on the fourth byte only.
- R2: With a count of 1 the block sends exactly 4 bytes, in this order: 0x15, the command, parameter 0, ECC. `out_last` is high on the fourth byte only.
- R3: With a count n ≥ 2 the block sends n+7 bytes. The order is:
  - 0x39
  - the low byte of n+1
  - the high byte of n+1
  - ECC
  - the command
  - parameters 0 to n-1
  - the checksum low byte
  - the checksum high byte

  Parameter k is `req_params[8k+7:8k]`. `out_last` is high on the final byte only.
- R4: The ECC byte is computed from H = byte0 | byte1<<8 | byte2<<16. Bit i is the XOR of all bits of H & M[i], with M = {0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0, 0xEFFC00} for i = 0 to 5. Bits 7:6 are 0.
- R5: The checksum covers the command byte and every parameter byte. Each byte is taken LSB first into a right-shifting CRC-16 with polynomial 0x8408 and start value 0xFFFF, with no final inversion.
- R6: A request accepted with a count above MAX_PARAMS produces `err` high for exactly one cycle, on the cycle after acceptance. No byte is sent, and the block stays ready.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values and no byte is lost.
- R8: `req_ready` is high exactly when no packet is in progress. Requests offered during a packet have no effect on the stream. The packet's first byte is valid on the cycle after acceptance.
- R9: After reset `out_valid` and `err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_cmd | input | 8 | Display command byte |
| req_cnt | input | CNT_W | Number of parameter bytes |
| req_params | input | MAX_PARAMS*8 | Parameter buffer, parameter k in bits 8k+7:8k |
| out_valid | output | 1 | Packet byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |
| err | output | 1 | One-cycle pulse for an oversized request |

## Verification
Counts of 0 and 1 separate the two short-packet type codes and the third header byte (filler versus parameter). A count of 2 is the smallest long packet and exercises the word count and checksum with the least payload. A full buffer checks the final parameter slot and the longest path through the payload state. Counts just above the depth and near the top of the count field show that rejection covers the whole oversized range. Random counts, commands and parameters with random downstream stalls check the ECC and checksum arithmetic against bench models. Requests driven in the middle of a packet show that a busy block ignores them.

// File: rtl/dcs_pkt_pkg.sv
package dcs_pkt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEADER,
        ST_PAYLOAD,
        ST_CHECKSUM
    } asm_state_t;

    localparam logic [7:0] TYPE_SHORT0 = 8'h05;
    localparam logic [7:0] TYPE_SHORT1 = 8'h15;
    localparam logic [7:0] TYPE_LONG   = 8'h39;

    localparam int          ECC_BITS = 6;
    localparam logic [23:0] ECC_MASK [ECC_BITS] = '{
        24'hF12CB7, 24'hF2555B, 24'h749A6D,
        24'hB8E38E, 24'hDF03F0, 24'hEFFC00
    };

    localparam logic [15:0] CRC_POLY = 16'h8408;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

endpackage

// File: rtl/dcs_hdr_ecc.sv
module dcs_hdr_ecc
    import dcs_pkt_pkg::*;
(
    input  logic [23:0] hdr,
    output logic [7:0]  ecc
);
    for (genvar i = 0; i < ECC_BITS; i++) begin : g_bit
        assign ecc[i] = ^(hdr & ECC_MASK[i]);
    end
    assign ecc[7:ECC_BITS] = '0;
endmodule

// File: rtl/dcs_crc_byte.sv
module dcs_crc_byte
    import dcs_pkt_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  din,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ din[b]) c = (c >> 1) ^ CRC_POLY;
            else               c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/dcs_pkt_asm.sv
module dcs_pkt_asm
    import dcs_pkt_pkg::*;
#(
    parameter int MAX_PARAMS = 8,
    parameter int CNT_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [7:0]              req_cmd,
    input  logic [CNT_W-1:0]        req_cnt,
    input  logic [MAX_PARAMS*8-1:0] req_params,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [7:0]              out_data,
    output logic                    out_last,
    output logic                    err
);
    localparam int             IDX_W  = $clog2(MAX_PARAMS + 1) + 1;
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PARAMS);

    asm_state_t              state, nxt;
    logic [IDX_W-1:0]        idx;
    logic [IDX_W-1:0]        pidx;
    logic [7:0]              cmd_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [MAX_PARAMS*8-1:0] par_q;
    logic [15:0]             crc_q, crc_nx;
    logic                    err_q;
    logic                    is_long, fire, accept, cnt_ok;
    logic [15:0]             wc;
    logic [7:0]              hb0, hb1, hb2, ecc;
    logic [7:0]              pay_byte;

    assign cnt_ok  = (req_cnt <= MAX_C);
    assign accept  = req_valid && (state == ST_IDLE);
    assign is_long = (cnt_q > CNT_W'(1));
    assign fire    = out_valid && out_ready;
    assign wc      = 16'(cnt_q) + 16'd1;
    assign pidx    = idx - 1'b1;

    assign hb0 = is_long ? TYPE_LONG : ((cnt_q == '0) ? TYPE_SHORT0 : TYPE_SHORT1);
    assign hb1 = is_long ? wc[7:0]  : cmd_q;
    assign hb2 = is_long ? wc[15:8] : ((cnt_q == '0) ? 8'h00 : par_q[7:0]);

    assign pay_byte = (idx == '0) ? cmd_q : par_q[{pidx, 3'b000} +: 8];

    dcs_hdr_ecc u_ecc (
        .hdr ({hb2, hb1, hb0}),
        .ecc (ecc)
    );

    dcs_crc_byte u_crc (
        .crc_in  (crc_q),
        .din     (pay_byte),
        .crc_out (crc_nx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (accept && cnt_ok) nxt = ST_HEADER;
            ST_HEADER:   if (fire && idx == IDX_W'(3)) nxt = is_long ? ST_PAYLOAD : ST_IDLE;
            ST_PAYLOAD:  if (fire && idx == IDX_W'(cnt_q)) nxt = ST_CHECKSUM;
            ST_CHECKSUM: if (fire && idx == IDX_W'(1)) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            cmd_q <= '0;
            cnt_q <= '0;
            par_q <= '0;
            crc_q <= CRC_SEED;
            err_q <= 1'b0;
        end else begin
            err_q <= accept && !cnt_ok;
            if (accept && cnt_ok) begin
                cmd_q <= req_cmd;
                cnt_q <= req_cnt;
                par_q <= req_params;
                crc_q <= CRC_SEED;
            end
            if (nxt != state)  idx <= '0;
            else if (fire)     idx <= idx + 1'b1;
            if (state == ST_PAYLOAD && fire) crc_q <= crc_nx;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HEADER: begin
                out_valid = 1'b1;
                unique case (idx[1:0])
                    2'd0: out_data = hb0;
                    2'd1: out_data = hb1;
                    2'd2: out_data = hb2;
                    default: out_data = ecc;
                endcase
                out_last = !is_long && (idx == IDX_W'(3));
            end
            ST_PAYLOAD: begin
                out_valid = 1'b1;
                out_data  = pay_byte;
            end
            ST_CHECKSUM: begin
                out_valid = 1'b1;
                out_data  = idx[0] ? crc_q[15:8] : crc_q[7:0];
                out_last  = idx[0];
            end
            default: ;
        endcase
        req_ready = (state == ST_IDLE);
        err       = err_q;
    end
endmodule

// File: rtl/dcs_pkt_asm_chk.sv
module dcs_pkt_asm_chk #(
    parameter int MAX_PARAMS = 8,
    parameter int CNT_W      = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [CNT_W-1:0]        req_cnt,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [7:0]              out_data,
    input logic                    out_last,
    input logic                    err
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PARAMS);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !out_valid);

    assert_start_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cnt <= MAX_C) |=>
        (out_valid && (out_data == 8'h05 || out_data == 8'h15 || out_data == 8'h39)));

    assert_reject_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cnt > MAX_C) |=> (err && !out_valid && req_ready));

    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> req_ready);
endmodule

bind dcs_pkt_asm dcs_pkt_asm_chk #(.MAX_PARAMS(MAX_PARAMS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cnt   (req_cnt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .err       (err)
);

// File: tb/dcs_pkt_asm_bench.sv
module dcs_pkt_asm_bench;
    localparam int MAXP  = 8;
    localparam int CW    = 8;
    localparam int MAXLEN = MAXP + 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [7:0]      req_cmd = '0;
    logic [CW-1:0]   req_cnt = '0;
    logic [MAXP*8-1:0] req_params = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [7:0]      out_data;
    logic            out_last;
    logic            err;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_b [MAXLEN];
    int         exp_len;

    always #2 clk = ~clk;

    dcs_pkt_asm #(.MAX_PARAMS(MAXP), .CNT_W(CW)) u_dcs_pkt_asm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_cnt(req_cnt), .req_params(req_params),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .err(err)
    );

    function automatic logic [7:0] ecc_f(input logic [7:0] a, b, c);
        logic [23:0] m [6];
        logic [23:0] h;
        logic [7:0]  r;
        m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
        m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
        h = {c, b, a};
        r = 8'h00;
        for (int i = 0; i < 6; i++) r[i] = ^(h & m[i]);
        return r;
    endfunction

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c;
        for (int b = 0; b < 8; b++)
            x = (x[0] ^ d[b]) ? ((x >> 1) ^ 16'h8408) : (x >> 1);
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic build(input logic [7:0] cmd, input int cnt, input logic [MAXP*8-1:0] p);
        logic [15:0] crc;
        if (cnt == 0) begin
            exp_b[0] = 8'h05; exp_b[1] = cmd; exp_b[2] = 8'h00;
            exp_b[3] = ecc_f(8'h05, cmd, 8'h00); exp_len = 4;
        end else if (cnt == 1) begin
            exp_b[0] = 8'h15; exp_b[1] = cmd; exp_b[2] = p[7:0];
            exp_b[3] = ecc_f(8'h15, cmd, p[7:0]); exp_len = 4;
        end else begin
            exp_b[0] = 8'h39;
            exp_b[1] = 8'((cnt + 1) & 255);
            exp_b[2] = 8'((cnt + 1) >> 8);
            exp_b[3] = ecc_f(exp_b[0], exp_b[1], exp_b[2]);
            exp_b[4] = cmd;
            crc = crc_upd(16'hFFFF, cmd);
            for (int k = 0; k < cnt; k++) begin
                exp_b[5 + k] = p[8*k +: 8];
                crc = crc_upd(crc, p[8*k +: 8]);
            end
            exp_b[5 + cnt] = crc[7:0];
            exp_b[6 + cnt] = crc[15:8];
            exp_len = cnt + 7;
        end
    endtask

    task automatic run_pkt(input logic [7:0] cmd, input int cnt,
                           input logic [MAXP*8-1:0] p, input int busy_reqs);
        int n;
        int iter;
        bit stall;
        logic [7:0] prev_d;
        logic prev_l;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_cnt = CW'(cnt); req_params = p;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (cnt > MAXP) begin
            check(err == 1'b1, "R6", "err pulse", int'(err), 1);
            check(!out_valid && req_ready, "R6", "no output on reject", int'(out_valid), 0);
            @(negedge clk); #1;
            check(err == 1'b0 && !out_valid, "R6", "err single cycle", int'(err), 0);
            return;
        end
        check(err == 1'b0, "R6", "no err on valid count", int'(err), 0);
        check(out_valid == 1'b1, "R8", "first byte next cycle", int'(out_valid), 1);
        build(cmd, cnt, p);
        n = 0; iter = 0; stall = 1'b0; prev_d = '0; prev_l = 1'b0;
        while (n < exp_len && iter < 400) begin
            out_ready = ($urandom_range(0, 9) < 7);
            if (busy_reqs > 0) begin
                req_valid = 1'b1; req_cmd = 8'hEE; req_cnt = CW'(0);
                busy_reqs--;
            end else req_valid = 1'b0;
            #1;
            if (busy_reqs >= 0 && req_valid)
                check(!req_ready, "R8", "busy while streaming", int'(req_ready), 0);
            if (stall)
                check(out_data == prev_d && out_last == prev_l, "R7",
                      "hold under stall", int'(out_data), int'(prev_d));
            if (!out_valid) check(1'b0, "R3", "valid dropped mid packet", 0, 1);
            if (out_ready && out_valid) begin
                check(out_data == exp_b[n],
                      cnt == 0 ? "R1" : (cnt == 1 ? "R2" : (n == 3 ? "R4" : (n >= exp_len - 2 ? "R5" : "R3"))),
                      $sformatf("byte %0d", n), int'(out_data), int'(exp_b[n]));
                check(out_last == (n == exp_len - 1), cnt < 2 ? "R1" : "R3",
                      $sformatf("last at byte %0d", n), int'(out_last), int'(n == exp_len - 1));
                n++;
            end
            stall = out_valid && !out_ready;
            prev_d = out_data; prev_l = out_last;
            @(negedge clk);
            iter++;
        end
        req_valid = 1'b0;
        out_ready = 1'b0;
        #1;
        check(!out_valid && req_ready, "R8", "idle after packet, busy requests ignored",
              int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..none actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [MAXP*8-1:0] p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && !err && req_ready, "R9", "reset outputs",
              {29'd0, out_valid, err, req_ready}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && !err && req_ready, "R9", "after reset release",
              {29'd0, out_valid, err, req_ready}, 1);

        p = {8'h88, 8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11};
        run_pkt(8'h29, 0, p, 0);          // R1 directed
        run_pkt(8'h36, 1, p, 0);          // R2 directed
        run_pkt(8'h2C, 2, p, 0);          // R3 smallest long
        run_pkt(8'h51, MAXP, p, 3);       // R3 full buffer, R8 busy requests
        run_pkt(8'h11, MAXP + 1, p, 0);   // R6 just above depth
        run_pkt(8'h11, 255, p, 0);        // R6 top of count range
        run_pkt(8'h00, 2, '0, 0);         // R5 zero data
        run_pkt(8'hFF, MAXP, '1, 2);      // R5 all ones

        for (int t = 0; t < 120; t++) begin
            int c;
            for (int k = 0; k < MAXP; k++) p[8*k +: 8] = 8'($urandom);
            c = ($urandom_range(0, 9) == 0) ? $urandom_range(MAXP + 1, 255)
                                            : $urandom_range(0, MAXP);
            run_pkt(8'($urandom), c, p, $urandom_range(0, 3));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule